// File: doc/BRIEF.md
# NOR Flash Command Engine

This block sits behind a simple synchronous memory port and makes an on-chip word array behave like a parallel NOR flash with the classic two-cycle command set. Bus writes are decoded as command bytes from the low data lane. The block tracks whether it is idle or armed for a second cycle, and it remembers what reads should return. A read can return array contents, the status byte, the identifier bytes or the query table.

A program stores one word. An erase sets a whole aligned block to all ones, and the erase needs a confirm byte. A write-protect input blocks both program and erase and records the failure in the status byte. After each accepted program or erase, the ready bit stays low for a fixed number of cycles set by a parameter. Commands are still decoded during that time. A byte sequence that is not recognised returns the engine to array reads.

Top module: `nor_cmd_engine`

## Requirements
- R1: After reset, the whole array reads as all ones, reads return array data, and the status byte is 0x80.
- R2: A write of 0x10 or 0x40 while idle arms a program. The next write stores its full data word at its address. Reads then return status until the mode is changed.
- R3: A write of 0x20 or 0x28 while idle, followed by 0xD0, sets every word of the block containing the second address to all ones. The block is SECTOR_WORDS words long and aligned. Words outside that block keep their values.
- R4: After an erase is armed, a second byte of 0xFF, or of any value other than 0xD0, erases nothing and returns reads to array data.
- R5: With wp high, a program leaves the array unchanged and sets status bit 4. An erase leaves the array unchanged and sets status bit 5. Bit 7 stays 1 in both cases.
- R6: Status bit 7 reads 0 on the first BUSY_CYCLES read edges after an accepted program or erase, and 1 afterwards. The byte 0x70 selects status reads. In status reads, the status byte is copied into every 8-bit lane of rdata.
- R7: The byte 0x50 clears status bits 4 and 5 and returns reads to array data.
- R8: The byte 0x90 selects identifier reads. Address 0 returns MFR_ID, address 1 returns DEV_ID, and any other address returns 0, each copied into every lane.
- R9: The byte 0x98 selects query reads. Addresses 0x10, 0x11 and 0x12 return 0x51, 0x52 and 0x59. Address 0x13 returns 0x01. Address 0x27 returns log2 of the array size in bytes. Any other address returns 0. Each value is copied into every lane.
- R10: A write of 0x60 while idle arms lock handling. A second byte of 0xD0 or 0x01 selects status reads. Any other second byte returns reads to array data. The array never changes.
- R11: An unrecognised byte while idle returns reads to array data. While identifier or query reads are selected, a write of 0xFF returns to array reads, and any other byte is decoded as a new command.
- R12: rdata takes the selected value on the clock edge where rd_en is high, and it holds its value on edges where rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per bus write |
| rd_en | input | 1 | Read strobe, one cycle per bus read |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data; the command byte is bits 7:0 |
| wp | input | 1 | Write protect for program and erase |
| rdata | output | DATA_W | Registered read data |

## Verification
A write changes the mode, the array and the status on the same edge. A read strobe loads rdata on its own edge, so the bench drives each strobe at a falling edge and samples rdata at the next falling edge. For the ready bit, BUSY_CYCLES is counted from the edge that performs the program or erase. The bench reads directly after the data write to see bit 7 low, then idles past the busy window before it expects bit 7 high again. Array contents are compared against a bench model that is updated only by the requirement rules.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
  typedef enum logic [1:0] {RM_ARRAY, RM_STATUS, RM_IDENT, RM_QUERY} readMode_e;
  typedef enum logic [1:0] {PH_IDLE, PH_PROG, PH_ERASE, PH_LOCK} phase_e;

  typedef struct packed {
    logic prog;
    logic erase;
    logic clrStatus;
  } strobes_t;

  localparam logic [7:0] C_PROG_A  = 8'h10;
  localparam logic [7:0] C_PROG_B  = 8'h40;
  localparam logic [7:0] C_ERASE_A = 8'h20;
  localparam logic [7:0] C_ERASE_B = 8'h28;
  localparam logic [7:0] C_CLEAR   = 8'h50;
  localparam logic [7:0] C_LOCK    = 8'h60;
  localparam logic [7:0] C_STATUS  = 8'h70;
  localparam logic [7:0] C_IDENT   = 8'h90;
  localparam logic [7:0] C_QUERY   = 8'h98;
  localparam logic [7:0] C_CONFIRM = 8'hD0;
  localparam logic [7:0] C_LOCKALT = 8'h01;
  localparam logic [7:0] C_ARRAY   = 8'hFF;

  function automatic logic isFirstCycleCmd(input logic [7:0] b);
    return b inside {C_PROG_A, C_PROG_B, C_ERASE_A, C_ERASE_B, C_CLEAR,
                     C_LOCK, C_STATUS, C_IDENT, C_QUERY};
  endfunction
endpackage

// File: rtl/nfc_ctrl.sv
module nfc_ctrl
  import nfc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wrEn,
  input  logic [7:0] cmdByte,
  output readMode_e  readMode,
  output strobes_t   stb
);
  phase_e    phaseQ, phaseN;
  readMode_e modeQ, modeN;

  always_comb begin
    phaseN = phaseQ;
    modeN  = modeQ;
    stb    = '0;
    if (wrEn) begin
      phaseN = PH_IDLE;
      unique case (phaseQ)
        PH_IDLE: begin
          case (cmdByte)
            C_PROG_A, C_PROG_B:   begin phaseN = PH_PROG;  modeN = RM_STATUS; end
            C_ERASE_A, C_ERASE_B: begin phaseN = PH_ERASE; modeN = RM_STATUS; end
            C_LOCK:               begin phaseN = PH_LOCK;  modeN = RM_STATUS; end
            C_CLEAR:              begin stb.clrStatus = 1'b1; modeN = RM_ARRAY; end
            C_STATUS:             modeN = RM_STATUS;
            C_IDENT:              modeN = RM_IDENT;
            C_QUERY:              modeN = RM_QUERY;
            default:              modeN = RM_ARRAY;
          endcase
        end
        PH_PROG: begin
          stb.prog = 1'b1;
          modeN    = RM_STATUS;
        end
        PH_ERASE: begin
          if (cmdByte == C_CONFIRM) begin
            stb.erase = 1'b1;
            modeN     = RM_STATUS;
          end else begin
            modeN = RM_ARRAY;
          end
        end
        PH_LOCK: begin
          if (cmdByte == C_CONFIRM || cmdByte == C_LOCKALT) modeN = RM_STATUS;
          else                                              modeN = RM_ARRAY;
        end
        default: modeN = RM_ARRAY;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phaseQ <= PH_IDLE;
      modeQ  <= RM_ARRAY;
    end else begin
      phaseQ <= phaseN;
      modeQ  <= modeN;
    end
  end

  assign readMode = modeQ;

  // R2: a program opcode while idle arms the data cycle
  a_r2_arm_prog: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn && phaseQ == PH_IDLE && (cmdByte == C_PROG_A || cmdByte == C_PROG_B)
    |=> phaseQ == PH_PROG && modeQ == RM_STATUS);

  // R4: an armed erase without confirm ends in array reads
  a_r4_abort_array: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn && phaseQ == PH_ERASE && cmdByte != C_CONFIRM
    |=> modeQ == RM_ARRAY && phaseQ == PH_IDLE);

  // R11: unknown first byte falls back to array reads
  a_r11_unknown_array: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn && phaseQ == PH_IDLE && !isFirstCycleCmd(cmdByte)
    |=> modeQ == RM_ARRAY && phaseQ == PH_IDLE);

  // R10: lock sequence never arms a second cycle
  a_r10_lock_done: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn && phaseQ == PH_LOCK |=> phaseQ == PH_IDLE);
endmodule

// File: rtl/nfc_data.sv
module nfc_data
  import nfc_pkg::*;
#(
  parameter int          ADDR_W       = 8,
  parameter int          DATA_W       = 16,
  parameter int          SECTOR_WORDS = 16,
  parameter int          BUSY_CYCLES  = 3,
  parameter logic [7:0]  MFR_ID       = 8'h89,
  parameter logic [7:0]  DEV_ID       = 8'h18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobes_t          stb,
  input  readMode_e         readMode,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wp,
  output logic [DATA_W-1:0] rdata
);
  localparam int WORDS      = 1 << ADDR_W;
  localparam int LANES      = DATA_W / 8;
  localparam int SECT_SHIFT = $clog2(SECTOR_WORDS);
  localparam int BUSY_W     = $clog2(BUSY_CYCLES + 2);
  localparam logic [7:0] SIZE_LOG2 = 8'(ADDR_W + $clog2(LANES));

  logic [DATA_W-1:0] mem [WORDS];
  logic [ADDR_W-1:0] blockBase;
  logic              progErr, eraseErr;
  logic [BUSY_W-1:0] busyCnt;
  logic              ready;
  logic [7:0]        statusByte, identByte, queryByte;

  assign blockBase = (addr >> SECT_SHIFT) << SECT_SHIFT;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
    end else if (stb.prog && !wp) begin
      mem[addr] <= wdata;
    end else if (stb.erase && !wp) begin
      for (int i = 0; i < SECTOR_WORDS; i++) mem[blockBase + ADDR_W'(i)] <= '1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      progErr  <= 1'b0;
      eraseErr <= 1'b0;
      busyCnt  <= '0;
    end else begin
      if (stb.clrStatus) begin
        progErr  <= 1'b0;
        eraseErr <= 1'b0;
      end
      if (stb.prog && wp)  progErr  <= 1'b1;
      if (stb.erase && wp) eraseErr <= 1'b1;
      if ((stb.prog || stb.erase) && !wp) busyCnt <= BUSY_W'(BUSY_CYCLES);
      else if (busyCnt != '0)             busyCnt <= busyCnt - BUSY_W'(1);
    end
  end

  assign ready      = (busyCnt == '0);
  assign statusByte = {ready, 1'b0, eraseErr, progErr, 4'b0000};

  always_comb begin
    if (addr == ADDR_W'(0))      identByte = MFR_ID;
    else if (addr == ADDR_W'(1)) identByte = DEV_ID;
    else                         identByte = 8'h00;
  end

  always_comb begin
    case (addr)
      ADDR_W'('h10): queryByte = 8'h51;
      ADDR_W'('h11): queryByte = 8'h52;
      ADDR_W'('h12): queryByte = 8'h59;
      ADDR_W'('h13): queryByte = 8'h01;
      ADDR_W'('h27): queryByte = SIZE_LOG2;
      default:       queryByte = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rdEn) begin
      unique case (readMode)
        RM_ARRAY:  rdata <= mem[addr];
        RM_STATUS: rdata <= {LANES{statusByte}};
        RM_IDENT:  rdata <= {LANES{identByte}};
        RM_QUERY:  rdata <= {LANES{queryByte}};
        default:   rdata <= mem[addr];
      endcase
    end
  end

  // R3: confirmed erase leaves the block base word all ones
  a_r3_erase_ones: assert property (@(posedge clk) disable iff (!rst_n)
    stb.erase && !wp |=> mem[$past(blockBase)] == '1);

  // R5: protected program leaves the word untouched and flags bit 4
  a_r5_wp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    stb.prog && wp |=> mem[$past(addr)] == $past(mem[addr]) && progErr);

  // R12: rdata holds without a read strobe
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rdEn |=> $stable(rdata));

  generate
    if (BUSY_CYCLES > 0) begin : g_busy
      // R6: accepted operation drops ready on the next edge
      a_r6_busy_low: assert property (@(posedge clk) disable iff (!rst_n)
        (stb.prog || stb.erase) && !wp |=> !ready);
    end
  endgenerate
endmodule

// File: rtl/nor_cmd_engine.sv
module nor_cmd_engine
  import nfc_pkg::*;
#(
  parameter int          ADDR_W       = 8,
  parameter int          DATA_W       = 16,
  parameter int          SECTOR_WORDS = 16,
  parameter int          BUSY_CYCLES  = 3,
  parameter logic [7:0]  MFR_ID       = 8'h89,
  parameter logic [7:0]  DEV_ID       = 8'h18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wp,
  output logic [DATA_W-1:0] rdata
);
  readMode_e readMode;
  strobes_t  stb;

  nfc_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wrEn     (wr_en),
    .cmdByte  (wdata[7:0]),
    .readMode (readMode),
    .stb      (stb)
  );

  nfc_data #(
    .ADDR_W       (ADDR_W),
    .DATA_W       (DATA_W),
    .SECTOR_WORDS (SECTOR_WORDS),
    .BUSY_CYCLES  (BUSY_CYCLES),
    .MFR_ID       (MFR_ID),
    .DEV_ID       (DEV_ID)
  ) u_data (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb      (stb),
    .readMode (readMode),
    .rdEn     (rd_en),
    .addr     (addr),
    .wdata    (wdata),
    .wp       (wp),
    .rdata    (rdata)
  );
endmodule

// File: tb/nor_cmd_engine_tb.sv
module nor_cmd_engine_tb;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int SW = 16;
  localparam int BUSY = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, wp = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] model [1 << AW];

  always #5 clk = ~clk;

  nor_cmd_engine #(.ADDR_W(AW), .DATA_W(DW), .SECTOR_WORDS(SW),
                   .BUSY_CYCLES(BUSY), .MFR_ID(8'h89), .DEV_ID(8'h18)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .wp(wp), .rdata(rdata));

  function automatic logic [DW-1:0] rep(input logic [7:0] b);
    return {b, b};
  endfunction

  function automatic logic [7:0] stat(input logic rdy, input logic ee, input logic pe);
    return {rdy, 1'b0, ee, pe, 4'b0000};
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] v);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic eraseModel(input logic [AW-1:0] a);
    for (int i = 0; i < SW; i++) model[((a / SW) * SW) + i] = '1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] v;
    for (int i = 0; i < (1 << AW); i++) model[i] = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(8'h00, v); check("R1 array erased", v, 16'hFFFF);
    rd(8'hC7, v); check("R1 array erased hi", v, 16'hFFFF);
    wr(8'h00, 16'h0070);
    rd(8'h00, v); check("R1 status 0x80", v, rep(8'h80));

    // R2 / R6 program, busy then ready
    wr(8'h05, 16'h0010);
    wr(8'h05, 16'h1234); model[5] = 16'h1234;
    rd(8'h00, v); check("R6 busy after program", v, rep(stat(1'b0, 1'b0, 1'b0)));
    idle(BUSY + 2);
    rd(8'h00, v); check("R6 ready after busy", v, rep(8'h80));
    rd(8'h05, v); check("R2 reads stay status", v, rep(8'h80));
    wr(8'h00, 16'h00FF);
    rd(8'h05, v); check("R2 programmed word", v, 16'h1234);
    wr(8'h06, 16'h0040);
    wr(8'h06, 16'hA5C3); model[6] = 16'hA5C3;
    wr(8'h00, 16'h00FF);
    rd(8'h06, v); check("R2 alt opcode 0x40", v, 16'hA5C3);

    // R3 erase with confirm
    wr(8'h23, 16'h0010); wr(8'h23, 16'hAAAA);
    wr(8'h2F, 16'h0010); wr(8'h2F, 16'h5555);
    wr(8'h30, 16'h0010); wr(8'h30, 16'h7777);
    wr(8'h25, 16'h0020); wr(8'h25, 16'h00D0);
    rd(8'h00, v); check("R6 busy after erase", v, 16'h0000);
    idle(BUSY + 2);
    wr(8'h00, 16'h00FF);
    rd(8'h23, v); check("R3 block word low", v, 16'hFFFF);
    rd(8'h2F, v); check("R3 block word top", v, 16'hFFFF);
    rd(8'h30, v); check("R3 next block kept", v, 16'h7777);
    wr(8'h31, 16'h0028); wr(8'h31, 16'h00D0);
    wr(8'h00, 16'h00FF);
    rd(8'h30, v); check("R3 alt opcode 0x28", v, 16'hFFFF);

    // R4 erase aborted
    wr(8'h40, 16'h0010); wr(8'h40, 16'h1111); model[8'h40] = 16'h1111;
    wr(8'h00, 16'h00FF);
    wr(8'h40, 16'h0020); wr(8'h40, 16'h00FF);
    rd(8'h40, v); check("R4 abort by 0xFF", v, 16'h1111);
    wr(8'h40, 16'h0020); wr(8'h40, 16'h0033);
    rd(8'h40, v); check("R4 invalid second byte", v, 16'h1111);

    // R5 write protect
    wp = 1'b1;
    wr(8'h50, 16'h0010); wr(8'h50, 16'hBEEF);
    rd(8'h00, v); check("R5 program error bit4", v, rep(8'h90));
    wr(8'h00, 16'h00FF);
    rd(8'h50, v); check("R5 word unchanged", v, 16'hFFFF);
    wr(8'h40, 16'h0020); wr(8'h40, 16'h00D0);
    rd(8'h00, v); check("R5 erase error bit5", v, rep(8'hB0));
    wr(8'h00, 16'h00FF);
    rd(8'h40, v); check("R5 block unchanged", v, 16'h1111);
    wp = 1'b0;

    // R7 clear status
    wr(8'h00, 16'h0050);
    rd(8'h40, v); check("R7 array after clear", v, 16'h1111);
    wr(8'h00, 16'h0070);
    rd(8'h00, v); check("R7 bits cleared", v, rep(8'h80));

    // R8 identifier, R9 query, R11 decode from ident
    wr(8'h00, 16'h0090);
    rd(8'h00, v); check("R8 maker", v, rep(8'h89));
    rd(8'h01, v); check("R8 device", v, rep(8'h18));
    rd(8'h02, v); check("R8 other zero", v, 16'h0000);
    wr(8'h00, 16'h0098);
    rd(8'h10, v); check("R9 Q", v, rep(8'h51));
    rd(8'h11, v); check("R9 R", v, rep(8'h52));
    rd(8'h12, v); check("R9 Y", v, rep(8'h59));
    rd(8'h13, v); check("R9 cmdset", v, rep(8'h01));
    rd(8'h27, v); check("R9 size log2", v, rep(8'h09));
    rd(8'h05, v); check("R9 other zero", v, 16'h0000);
    wr(8'h00, 16'h0070);
    rd(8'h00, v); check("R11 query decodes new cmd", v, rep(8'h80));
    wr(8'h00, 16'h0098);
    wr(8'h00, 16'h00FF);
    rd(8'h40, v); check("R11 0xFF leaves query", v, 16'h1111);

    // R10 lock handling
    wr(8'h40, 16'h0060); wr(8'h40, 16'h0001);
    rd(8'h40, v); check("R10 lock 0x01 status", v, rep(8'h80));
    wr(8'h40, 16'h0060); wr(8'h40, 16'h00D0);
    rd(8'h40, v); check("R10 lock 0xD0 status", v, rep(8'h80));
    wr(8'h40, 16'h0060); wr(8'h40, 16'h0077);
    rd(8'h40, v); check("R10 unknown lock array", v, 16'h1111);

    // R11 unknown first byte
    wr(8'h00, 16'h0070);
    wr(8'h00, 16'h0033);
    rd(8'h40, v); check("R11 unknown to array", v, 16'h1111);

    // R12 hold without strobe
    idle(4);
    addr = 8'h05;
    idle(2);
    check("R12 rdata holds", rdata, 16'h1111);

    // Random program / erase / read against model
    void'($urandom(32'd4242));
    for (int k = 0; k < 80; k++) begin
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      int op;
      a  = AW'($urandom % (1 << AW));
      d  = DW'($urandom);
      op = int'($urandom % 5);
      if (op < 2) begin
        wr(a, (op == 0) ? 16'h0010 : 16'h0040);
        wr(a, d); model[a] = d;
        wr(8'h00, 16'h00FF);
      end else if (op == 2) begin
        wr(a, 16'h0020); wr(a, 16'h00D0); eraseModel(a);
        wr(8'h00, 16'h00FF);
      end else begin
        rd(a, v); check("R2 R3 random read", v, model[a]);
      end
    end
    for (int k = 0; k < 16; k++) begin
      logic [AW-1:0] a;
      a = AW'($urandom % (1 << AW));
      rd(a, v); check("R2 R3 random sweep", v, model[a]);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule